// File: doc/BRIEF.md
# Shared Transmit/Receive Descriptor Ring Controller

This block owns a table of buffer descriptors that transmit and receive share. Each descriptor has two 32-bit words: a length/flags word and a buffer pointer. A split register divides the table. Transmit uses entries 0 up to split-1. Receive uses entries from split up to the last entry. The block tracks the current transmit and receive indices. It offers a transmit job when the current transmit descriptor is ready, and it accepts receive completions while the current receive descriptor is empty. When a job finishes, it updates the descriptor in place, advances the index (with wrap), and raises interrupt sources that pass through a mask.

Packet data movement is outside this block. A transmit job is offered on a valid/ready pair (`txs_valid`/`txs_ready`):
- `txs_valid` is high only while the start conditions hold. It can drop without a handshake if software rewrites the descriptor or the mode.
- A job counts as taken in a cycle where both `txs_valid` and `txs_ready` are high. After that, no further job is offered until a `txd_valid` pulse reports completion.

Receive completions arrive on `rxd_valid` with a length. They are taken only in cycles where `rxd_ready` is high, and a completion presented while `rxd_ready` is low is dropped, not held. Software reaches the control registers through the `cfg_*` pins and the descriptor table through the `dt_*` pins. All writes take effect at the next clock edge, and all reads are combinational.

Top module: `dring_ctrl`

## Requirements
- R1: After `rst_n` the control registers read as follows:
  - mode (`cfg_addr` 0) reads 0x0000A000
  - split (`cfg_addr` 1) reads 0x40
  - interrupt source (`cfg_addr` 2) and interrupt mask (`cfg_addr` 3) read 0
  - `tx_idx` is 0, `rx_idx` is 0x40, and `irq` is 0.
- R2: `txs_valid` is high exactly when all of the following hold:
  - mode bit 1 (transmit enable) is set
  - split is nonzero
  - no job is in flight
  - the current transmit descriptor has bit 15 (ready) set
  - its length field (bits 31:16) is greater than 4.
  When `txs_valid` is high, `txs_len` and `txs_ptr` give that length and the descriptor's pointer word.
- R3: On a transmit completion, `tx_idx` becomes 0 if the descriptor's bit 13 (wrap) is set. Otherwise it increments, and returns to 0 when the incremented value is at least split. The 7-bit index rolls over from 127 to 0.
- R4: A transmit completion clears the following bits of the descriptor's flag word and keeps all others:
  - bit 15
  - bit 8
  - bits 7:4
  - bits 3:0
  If bit 14 (interrupt request) was set, interrupt source bit 0 becomes 1.
- R5: `rxd_ready` is high exactly when mode bit 0 (receive enable) is set, split is below 0x80, and the current receive descriptor has bit 15 (empty) set.
- R6: An accepted receive completion writes `rxd_len` into bits 31:16 of the descriptor, clears bit 15, and keeps bits 14:0. `rx_idx` then returns to the split value if bit 13 is set or the index is 0x7F, and otherwise increments. If bit 14 was set, interrupt source bit 2 becomes 1.
- R7: A write that takes mode bit 0 from 0 to 1 loads `rx_idx` with split. A write that takes mode bit 1 from 0 to 1 sets `tx_idx` to 0.
- R8: Writing the interrupt source register clears each bit written as 1 and leaves the others unchanged. `irq` is the OR of (source AND mask) over bits 2:0.
- R9: A mode write that takes bit 11 from 0 to 1 does all of the following:
  - restores split, source, mask, `tx_idx` and `rx_idx` to their R1 values
  - abandons any job in flight
  - stores the written value as the new mode.
- R10: The descriptor table is addressed in bytes on `dt_addr`:
  - word w = `dt_addr`[9:2]
  - entry n is made of word 2n (flags) and word 2n+1 (pointer)
  - writes with `dt_addr`[1:0] nonzero are dropped
  - a write re-evaluates the transmit start on the next cycle.
- R11: A `txd_valid` pulse while no job is in flight, or an `rxd_valid` pulse while `rxd_ready` is low, changes neither the indices, the table nor the interrupt source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 2 | Control register select: 0 mode, 1 split, 2 source, 3 mask |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| dt_we | input | 1 | Descriptor table write strobe |
| dt_addr | input | 10 | Descriptor table byte address |
| dt_wdata | input | 32 | Descriptor table write data |
| dt_rdata | output | 32 | Descriptor table read data |
| txs_valid | output | 1 | Transmit job offered |
| txs_ready | input | 1 | Transmit job taken |
| txs_len | output | 16 | Length of offered job |
| txs_ptr | output | 32 | Buffer pointer of offered job |
| txd_valid | input | 1 | Transmit completion pulse |
| rxd_valid | input | 1 | Receive completion presented |
| rxd_ready | output | 1 | Receive completion can be taken |
| rxd_len | input | 16 | Received length |
| rxb_ptr | output | 32 | Buffer pointer of the current receive descriptor |
| tx_idx | output | 7 | Current transmit descriptor index |
| rx_idx | output | 7 | Current receive descriptor index |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default table size of 128 entries. At that size, the receive index can reach 0x7F and wrap back to split, and split can be written to 0x80 or above so that receive stops entirely. With the default split of 64, both rings are long enough for random descriptor contents to exercise both wrap conditions: the wrap flag and the hard boundary. Directed cases cover the length-of-4 start boundary, enable edges, soft reset and stray completions. These run before a long seeded random mix of table writes, handshakes, completions and register writes.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SRC_W      = 3;

  // descriptor flag positions shared by both rings
  localparam int unsigned F_OWN      = 15;
  localparam int unsigned F_IRQ      = 14;
  localparam int unsigned F_WRAP     = 13;
  localparam logic [WORD_W-1:0] TX_CLR_MASK = 32'h0000_81FF;

  // mode register bits
  localparam int unsigned M_RXEN     = 0;
  localparam int unsigned M_TXEN     = 1;
  localparam int unsigned M_SRST     = 11;
  localparam logic [WORD_W-1:0] MODE_DEF = 32'h0000_A000;

  // interrupt source bit positions
  localparam int unsigned S_TX       = 0;
  localparam int unsigned S_RX       = 2;

  typedef enum logic [1:0] {
    CFG_MODE  = 2'd0,
    CFG_SPLIT = 2'd1,
    CFG_SRC   = 2'd2,
    CFG_MASK  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int unsigned DESC_CNT = 128,
  localparam int unsigned IDX_W   = $clog2(DESC_CNT),
  localparam int unsigned SPLIT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic               tx_irq_set,
  input  logic               rx_irq_set,
  output logic               tx_en,
  output logic               rx_en,
  output logic [SPLIT_W-1:0] split,
  output logic               soft_rst,
  output logic               tx_load,
  output logic               rx_load,
  output logic               irq
);
  localparam logic [SPLIT_W-1:0] DEF_SPLIT = SPLIT_W'(DESC_CNT / 2);

  logic [WORD_W-1:0]  mode_q;
  logic [SPLIT_W-1:0] split_q;
  logic [SRC_W-1:0]   src_q, mask_q, src_nxt, src_clr, src_set;
  logic [WORD_W-1:0]  rise;
  logic               mode_wr;

  assign mode_wr  = cfg_we && (cfg_addr == CFG_MODE);
  assign rise     = cfg_wdata & ~mode_q;
  assign soft_rst = mode_wr && rise[M_SRST];
  assign rx_load  = mode_wr && rise[M_RXEN];
  assign tx_load  = mode_wr && rise[M_TXEN];

  assign src_clr = (cfg_we && cfg_addr == CFG_SRC) ? cfg_wdata[SRC_W-1:0] : '0;
  always_comb begin
    src_set = '0;
    src_set[S_TX] = tx_irq_set;
    src_set[S_RX] = rx_irq_set;
  end
  assign src_nxt = (src_q & ~src_clr) | src_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_DEF;
      split_q <= DEF_SPLIT;
      src_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (soft_rst) begin
        split_q <= DEF_SPLIT;
        src_q   <= '0;
        mask_q  <= '0;
      end else begin
        if (cfg_we && cfg_addr == CFG_SPLIT) split_q <= cfg_wdata[SPLIT_W-1:0];
        if (cfg_we && cfg_addr == CFG_MASK)  mask_q  <= cfg_wdata[SRC_W-1:0];
        src_q <= src_nxt;
      end
      if (mode_wr) mode_q <= cfg_wdata;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      CFG_MODE:  cfg_rdata = mode_q;
      CFG_SPLIT: cfg_rdata = WORD_W'(split_q);
      CFG_SRC:   cfg_rdata = WORD_W'(src_q);
      default:   cfg_rdata = WORD_W'(mask_q);
    endcase
  end

  assign tx_en = mode_q[M_TXEN];
  assign rx_en = mode_q[M_RXEN];
  assign split = split_q;
  assign irq   = |(src_q & mask_q);

  // R8
  src_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_SRC && !tx_irq_set && !rx_irq_set)
      |=> ((src_q & $past(cfg_wdata[SRC_W-1:0])) == '0));

  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (split_q == DEF_SPLIT && mask_q == '0 && src_q == '0));
endmodule

// File: rtl/dring_table.sv
module dring_table
  import dring_pkg::*;
#(
  parameter int unsigned DESC_CNT = 128,
  localparam int unsigned IDX_W    = $clog2(DESC_CNT),
  localparam int unsigned WADDR_W  = IDX_W + 1,
  localparam int unsigned WORD_CNT = 2 * DESC_CNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [WADDR_W-1:0] host_waddr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic [IDX_W-1:0]   tx_idx,
  input  logic               tx_we,
  input  logic [WORD_W-1:0]  tx_wdata,
  output logic [WORD_W-1:0]  tx_flags,
  output logic [WORD_W-1:0]  tx_ptr,
  input  logic [IDX_W-1:0]   rx_idx,
  input  logic               rx_we,
  input  logic [WORD_W-1:0]  rx_wdata,
  output logic [LEN_W-1:0]   rx_flags_lo,
  output logic [WORD_W-1:0]  rx_ptr
);
  logic [WORD_W-1:0]  mem [WORD_CNT];
  logic [WADDR_W-1:0] tx_wa, rx_wa;
  logic [WORD_W-1:0]  rx_flags;

  assign tx_wa = {tx_idx, 1'b0};
  assign rx_wa = {rx_idx, 1'b0};

  // later writes take precedence: engine updates win over host writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORD_CNT; w++) mem[w] <= '0;
    end else begin
      if (host_we) mem[host_waddr] <= host_wdata;
      if (tx_we)   mem[tx_wa]      <= tx_wdata;
      if (rx_we)   mem[rx_wa]      <= rx_wdata;
    end
  end

  assign host_rdata  = mem[host_waddr];
  assign tx_flags    = mem[tx_wa];
  assign tx_ptr      = mem[{tx_idx, 1'b1}];
  assign rx_flags    = mem[rx_wa];
  assign rx_flags_lo = rx_flags[LEN_W-1:0];
  assign rx_ptr      = mem[{rx_idx, 1'b1}];

  // R4
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && !(rx_we && rx_wa == tx_wa)) |=> ((mem[$past(tx_wa)] & TX_CLR_MASK) == '0));

  // R6
  rx_empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |=> !mem[$past(rx_wa)][F_OWN]);
endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter int unsigned DESC_CNT = 128,
  localparam int unsigned IDX_W   = $clog2(DESC_CNT),
  localparam int unsigned SPLIT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic [SPLIT_W-1:0] split,
  input  logic               soft_rst,
  input  logic               tx_load,
  input  logic               rx_load,
  input  logic [WORD_W-1:0]  tx_flags,
  input  logic [LEN_W-1:0]   rx_flags_lo,
  output logic               txs_valid,
  input  logic               txs_ready,
  output logic [LEN_W-1:0]   txs_len,
  input  logic               txd_valid,
  input  logic               rxd_valid,
  output logic               rxd_ready,
  input  logic [LEN_W-1:0]   rxd_len,
  output logic [IDX_W-1:0]   tx_idx,
  output logic [IDX_W-1:0]   rx_idx,
  output logic               tx_we,
  output logic [WORD_W-1:0]  tx_wdata,
  output logic               rx_we,
  output logic [WORD_W-1:0]  rx_wdata,
  output logic               tx_irq_set,
  output logic               rx_irq_set
);
  localparam logic [IDX_W-1:0] DEF_RX   = IDX_W'(DESC_CNT / 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_CNT - 1);
  localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(4);

  logic               busy;
  logic               tx_cmpl, rx_fire;
  logic [SPLIT_W-1:0] tx_inc;
  logic [IDX_W-1:0]   tx_nxt, rx_nxt;

  assign txs_len   = tx_flags[WORD_W-1:WORD_W-LEN_W];
  assign txs_valid = tx_en && (split != '0) && !busy && tx_flags[F_OWN] && (txs_len > MIN_LEN);
  assign tx_cmpl   = busy && txd_valid;

  assign rxd_ready = rx_en && !split[SPLIT_W-1] && rx_flags_lo[F_OWN];
  assign rx_fire   = rxd_valid && rxd_ready;

  assign tx_we      = tx_cmpl;
  assign tx_wdata   = tx_flags & ~TX_CLR_MASK;
  assign tx_irq_set = tx_cmpl && tx_flags[F_IRQ];

  always_comb begin
    rx_wdata = {rxd_len, rx_flags_lo};
    rx_wdata[F_OWN] = 1'b0;
  end
  assign rx_we      = rx_fire;
  assign rx_irq_set = rx_fire && rx_flags_lo[F_IRQ];

  assign tx_inc = {1'b0, tx_idx} + SPLIT_W'(1);
  assign tx_nxt = (tx_flags[F_WRAP] || tx_inc >= split) ? '0 : tx_inc[IDX_W-1:0];
  assign rx_nxt = (rx_flags_lo[F_WRAP] || rx_idx == LAST_IDX) ? split[IDX_W-1:0] : rx_idx + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_idx <= '0;
      rx_idx <= DEF_RX;
      busy   <= 1'b0;
    end else begin
      if (soft_rst || tx_load) tx_idx <= '0;
      else if (tx_cmpl)        tx_idx <= tx_nxt;

      if (rx_load)       rx_idx <= soft_rst ? DEF_RX : split[IDX_W-1:0];
      else if (soft_rst) rx_idx <= DEF_RX;
      else if (rx_fire)  rx_idx <= rx_nxt;

      if (soft_rst)                    busy <= 1'b0;
      else if (txs_valid && txs_ready) busy <= 1'b1;
      else if (tx_cmpl)                busy <= 1'b0;
    end
  end

  // R2
  busy_from_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(txs_valid && txs_ready));

  // R3
  tx_idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmpl && tx_flags[F_WRAP] && !tx_load && !soft_rst) |=> (tx_idx == '0));

  // R7
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !soft_rst) |=> (rx_idx == $past(split[IDX_W-1:0])));

  // R11
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_valid && !busy && !tx_load && !soft_rst) |=> (tx_idx == $past(tx_idx)));
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int unsigned DESC_CNT = 128,
  localparam int unsigned IDX_W   = $clog2(DESC_CNT),
  localparam int unsigned SPLIT_W = IDX_W + 1,
  localparam int unsigned WADDR_W = IDX_W + 1,
  localparam int unsigned BADDR_W = WADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic               dt_we,
  input  logic [BADDR_W-1:0] dt_addr,
  input  logic [WORD_W-1:0]  dt_wdata,
  output logic [WORD_W-1:0]  dt_rdata,
  output logic               txs_valid,
  input  logic               txs_ready,
  output logic [LEN_W-1:0]   txs_len,
  output logic [WORD_W-1:0]  txs_ptr,
  input  logic               txd_valid,
  input  logic               rxd_valid,
  output logic               rxd_ready,
  input  logic [LEN_W-1:0]   rxd_len,
  output logic [WORD_W-1:0]  rxb_ptr,
  output logic [IDX_W-1:0]   tx_idx,
  output logic [IDX_W-1:0]   rx_idx,
  output logic               irq
);
  logic               tx_en, rx_en, soft_rst, tx_load, rx_load;
  logic [SPLIT_W-1:0] split;
  logic               tx_irq_set, rx_irq_set;
  logic               tx_we, rx_we, host_we;
  logic [WORD_W-1:0]  tx_wdata, rx_wdata, tx_flags;
  logic [LEN_W-1:0]   rx_flags_lo;

  assign host_we = dt_we && (dt_addr[1:0] == 2'b00);

  dring_regs #(.DESC_CNT(DESC_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_irq_set(tx_irq_set), .rx_irq_set(rx_irq_set),
    .tx_en(tx_en), .rx_en(rx_en), .split(split),
    .soft_rst(soft_rst), .tx_load(tx_load), .rx_load(rx_load), .irq(irq)
  );

  dring_table #(.DESC_CNT(DESC_CNT)) u_table (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_waddr(dt_addr[BADDR_W-1:2]),
    .host_wdata(dt_wdata), .host_rdata(dt_rdata),
    .tx_idx(tx_idx), .tx_we(tx_we), .tx_wdata(tx_wdata),
    .tx_flags(tx_flags), .tx_ptr(txs_ptr),
    .rx_idx(rx_idx), .rx_we(rx_we), .rx_wdata(rx_wdata),
    .rx_flags_lo(rx_flags_lo), .rx_ptr(rxb_ptr)
  );

  dring_seq #(.DESC_CNT(DESC_CNT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .rx_en(rx_en), .split(split),
    .soft_rst(soft_rst), .tx_load(tx_load), .rx_load(rx_load),
    .tx_flags(tx_flags), .rx_flags_lo(rx_flags_lo),
    .txs_valid(txs_valid), .txs_ready(txs_ready), .txs_len(txs_len),
    .txd_valid(txd_valid), .rxd_valid(rxd_valid), .rxd_ready(rxd_ready), .rxd_len(rxd_len),
    .tx_idx(tx_idx), .rx_idx(rx_idx),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_we(rx_we), .rx_wdata(rx_wdata),
    .tx_irq_set(tx_irq_set), .rx_irq_set(rx_irq_set)
  );
endmodule

// File: tb/dring_ctrl_bench.sv
`timescale 1ns/1ps
module dring_ctrl_bench;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        dt_we = 0;
  logic [9:0]  dt_addr = 0;
  logic [31:0] dt_wdata = 0, dt_rdata;
  logic        txs_valid, txs_ready = 0, txd_valid = 0;
  logic [15:0] txs_len;
  logic [31:0] txs_ptr, rxb_ptr;
  logic        rxd_valid = 0, rxd_ready;
  logic [15:0] rxd_len = 0;
  logic [6:0]  tx_idx, rx_idx;
  logic        irq;

  always #2.5 clk = ~clk;

  dring_ctrl #(.DESC_CNT(N)) u_dring_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dt_we(dt_we), .dt_addr(dt_addr), .dt_wdata(dt_wdata), .dt_rdata(dt_rdata),
    .txs_valid(txs_valid), .txs_ready(txs_ready), .txs_len(txs_len), .txs_ptr(txs_ptr),
    .txd_valid(txd_valid), .rxd_valid(rxd_valid), .rxd_ready(rxd_ready), .rxd_len(rxd_len),
    .rxb_ptr(rxb_ptr), .tx_idx(tx_idx), .rx_idx(rx_idx), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [31:0] m_tab [2*N];
  logic [31:0] m_mode;
  logic [7:0]  m_split;
  logic [2:0]  m_src, m_mask;
  int          m_tx, m_rx;
  bit          m_busy;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit f_txv();
    logic [31:0] w = m_tab[2*m_tx];
    return m_mode[1] && m_split != 0 && !m_busy && w[15] && w[31:16] > 4;
  endfunction

  function automatic bit f_rxr();
    return m_mode[0] && m_split < 8'h80 && m_tab[2*m_rx][15];
  endfunction

  task automatic check_all();
    chk("R2 txs_valid", 32'(txs_valid), 32'(f_txv()));
    chk("R5 rxd_ready", 32'(rxd_ready), 32'(f_rxr()));
    chk("R3 tx_idx", 32'(tx_idx), 32'(m_tx));
    chk("R6 rx_idx", 32'(rx_idx), 32'(m_rx));
    chk("R8 irq", 32'(irq), 32'(|(m_src & m_mask)));
    if (f_txv()) begin
      chk("R2 txs_len", 32'(txs_len), 32'(m_tab[2*m_tx][31:16]));
      chk("R2 txs_ptr", txs_ptr, m_tab[2*m_tx+1]);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic dt_write(int w, logic [31:0] d);
    dt_we = 1; dt_addr = 10'(w * 4); dt_wdata = d;
    tick(); dt_we = 0;
    m_tab[w] = d;
    check_all();
  endtask

  task automatic dt_check(int w, string req);
    dt_addr = 10'(w * 4); #0.5;
    chk(req, dt_rdata, m_tab[w]);
  endtask

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    logic [31:0] rise;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick(); cfg_we = 0;
    case (a)
      2'd0: begin
        rise = d & ~m_mode;
        if (rise[11]) begin
          m_split = 8'h40; m_src = 0; m_mask = 0; m_tx = 0; m_rx = 64; m_busy = 0;
        end
        m_mode = d;
        if (rise[0]) m_rx = int'(m_split[6:0]);
        if (rise[1]) m_tx = 0;
      end
      2'd1: m_split = d[7:0];
      2'd2: m_src = m_src & ~d[2:0];
      default: m_mask = d[2:0];
    endcase
    check_all();
  endtask

  task automatic cfg_check(logic [1:0] a, logic [31:0] exp, string req);
    cfg_addr = a; #0.5;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic tx_take();
    txs_ready = 1; tick(); txs_ready = 0;
    if (f_txv()) m_busy = 1;
    check_all();
  endtask

  task automatic tx_done();
    logic [31:0] w;
    txd_valid = 1; tick(); txd_valid = 0;
    if (m_busy) begin
      w = m_tab[2*m_tx];
      m_tab[2*m_tx] = w & ~32'h0000_81FF;
      if (w[14]) m_src[0] = 1'b1;
      if (w[13] || m_tx + 1 >= int'(m_split)) m_tx = 0;
      else m_tx = (m_tx + 1) % N;
      m_busy = 0;
    end
    check_all();
  endtask

  task automatic rx_done(logic [15:0] len);
    logic [31:0] w;
    bit ok = f_rxr();
    rxd_valid = 1; rxd_len = len; tick(); rxd_valid = 0;
    if (ok) begin
      w = m_tab[2*m_rx];
      m_tab[2*m_rx] = {len, 1'b0, w[14:0]};
      if (w[14]) m_src[2] = 1'b1;
      if (w[13] || m_rx == N - 1) m_rx = int'(m_split[6:0]);
      else m_rx = m_rx + 1;
    end
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    int rx_before;
    void'($urandom(32'h1357_2468));
    for (int w = 0; w < 2 * N; w++) m_tab[w] = 0;
    m_mode = 32'hA000; m_split = 8'h40; m_src = 0; m_mask = 0;
    m_tx = 0; m_rx = 64; m_busy = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1 reset values
    cfg_check(2'd0, 32'h0000_A000, "R1 mode");
    cfg_check(2'd1, 32'h40, "R1 split");
    cfg_check(2'd2, 32'h0, "R1 source");
    cfg_check(2'd3, 32'h0, "R1 mask");
    chk("R1 tx_idx", 32'(tx_idx), 32'h0);
    chk("R1 rx_idx", 32'(rx_idx), 32'h40);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 length boundary, R10 re-check after table write
    dt_write(1, 32'hCAFE_0000);
    dt_write(0, {16'd4, 16'hC1FF});
    cfg_write(2'd3, 32'h7);
    cfg_write(2'd0, 32'hA002);
    chk("R2 len4 no start", 32'(txs_valid), 32'h0);
    dt_write(0, {16'd5, 16'hC1FF});
    chk("R10 start after write", 32'(txs_valid), 32'h1);
    chk("R2 ptr", txs_ptr, 32'hCAFE_0000);
    // R10 misaligned write dropped
    dt_we = 1; dt_addr = 10'h002; dt_wdata = 32'hDEAD_BEEF; tick(); dt_we = 0;
    dt_check(0, "R10 misaligned write dropped");
    tx_take();
    chk("R2 no offer while busy", 32'(txs_valid), 32'h0);
    tx_done();
    dt_check(0, "R4 tx flag clear");
    chk("R4 irq after tx", 32'(irq), 32'h1);
    cfg_check(2'd2, 32'h1, "R4 source bit0");
    cfg_write(2'd2, 32'h1);
    chk("R8 w1c irq low", 32'(irq), 32'h0);
    // R11 stray tx done
    tx_done();
    chk("R11 stray txd idx", 32'(tx_idx), 32'(m_tx));

    // R6 hard boundary at 0x7F, R7 reload from split
    dt_write(2*126, 32'h0000_8000);
    dt_write(2*127, 32'h0000_C000);
    cfg_write(2'd1, 32'h7E);
    cfg_write(2'd0, 32'hA003);
    chk("R7 rx reload", 32'(rx_idx), 32'h7E);
    rx_done(16'd60);
    chk("R6 rx inc", 32'(rx_idx), 32'h7F);
    rx_done(16'd1514);
    chk("R6 rx hard wrap", 32'(rx_idx), 32'h7E);
    dt_check(2*127, "R6 rx len and empty");
    cfg_check(2'd2, 32'h4, "R6 source bit2");
    // R11 rx completion while not ready
    snap = m_tab[2*126];
    rx_done(16'd99);
    chk("R11 rx ignored idx", 32'(rx_idx), 32'h7E);
    dt_check(2*126, "R11 rx ignored table");
    chk("R11 snap", m_tab[2*126], snap);
    // R5 split 0x80 blocks receive
    dt_write(2*126, 32'h0000_8000);
    chk("R5 ready before", 32'(rxd_ready), 32'h1);
    cfg_write(2'd1, 32'h80);
    chk("R5 split 0x80", 32'(rxd_ready), 32'h0);
    // R9 soft reset
    cfg_write(2'd0, 32'hA800);
    cfg_check(2'd1, 32'h40, "R9 split");
    cfg_check(2'd0, 32'hA800, "R9 mode kept");
    chk("R9 rx_idx", 32'(rx_idx), 32'h40);
    cfg_write(2'd0, 32'hA003);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom % 12);
      case (op)
        0, 1, 2: begin
          int e = int'($urandom % N);
          logic [15:0] len = ($urandom % 3 == 0) ? 16'($urandom % 8) : 16'(60 + $urandom % 1000);
          logic [15:0] lo = 16'($urandom);
          lo[15] = ($urandom % 4) != 0;
          lo[13] = ($urandom % 8) == 0;
          dt_write(2 * e, {len, lo});
        end
        3: dt_write(2 * int'($urandom % N) + 1, $urandom);
        4, 5: if (f_txv()) tx_take(); else tx_done();
        6: tx_done();
        7, 8: begin
          rx_before = m_rx;
          rx_done(16'($urandom));
          dt_check(2 * rx_before, "R6 rx table");
        end
        9: cfg_write(2'd2, 32'($urandom % 8));
        10: cfg_write(2'd3, 32'($urandom % 8));
        default: begin
          int k = int'($urandom % 20);
          if (k == 0) cfg_write(2'd0, 32'hA800 | 32'($urandom % 4));
          else if (k < 3) cfg_write(2'd1, 32'($urandom % 160));
          else cfg_write(2'd0, 32'hA000 | 32'($urandom % 4));
        end
      endcase
      if (i % 50 == 0) dt_check(int'($urandom % (2 * N)), "R4 table contents");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule